// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to the state in which it can take ordinary traffic. Once reset is released it holds the command pins at NOP for a programmable power-up delay, which is 100 µs expressed in clock cycles. It then closes every bank with a precharge-all command and runs two auto-refresh cycles. Last, it programs the standard mode register and then the extended mode register. Each command waits out the required gap before the next one: tRP after the precharge, tRFC after each refresh and tMRD after each register load.

The contents of both mode registers are fixed at elaboration from natural parameters. These cover the burst length (or full page), sequential or interleaved ordering, CAS latency, single-location writes, the fraction of the array kept alive in self refresh and the output drive fraction. A parameter that names an unsupported setting stops elaboration. Clock enable is held high for the whole sequence. When the sequence is complete, a sticky ready flag rises, and from that point on the block leaves the bus at NOP so that the memory controller can take over.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the command pins show NOP {cs_n,ras_n,cas_n,we_n} = 0111 and init_done is low.
- R2: Counting the cycle of reset release as cycle 0, cycles 0 to PWRUP_CYC show NOP and the precharge-all command (0010) appears in cycle PWRUP_CYC+1.
- R3: The precharge-all command drives address bit 10 high.
- R4: The first auto refresh (0001) comes exactly TRP_CYC cycles after the precharge, and the second comes exactly TRFC_CYC cycles after the first.
- R5: The standard register load (0000) comes exactly TRFC_CYC cycles after the second refresh, with bank address 00.
- R6: The extended register load (0000) comes exactly TMRD_CYC cycles after the standard load, with bank address 10.
- R7: init_done first goes high exactly TMRD_CYC cycles after the extended load, then stays high, and from then on the pins stay at NOP.
- R8: Exactly one precharge, two refreshes and two loads are issued, in that order, with NOP on every other cycle.
- R9: cke is high on every cycle.
- R10: Standard word bits [2:0] hold the burst code: 1→000, 2→001, 4→010, 8→011, full page→111 (sequential only). Bit 3 is 1 for interleaved ordering.
- R11: Standard word bits [6:4] hold the CAS latency (1, 2 or 3). Bit 9 is 1 when writes are single-location. Bits [8:7], bits [11:10] and all bits above them are 0.
- R12: Extended word bits [2:0] hold the refresh fraction code (full 000, half 001, quarter 010), and bits [6:5] hold the drive code (full 00, half 01, quarter 10, eighth 11). All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus, carrying the mode words during loads |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The bench runs eight configurations side by side. Across them, the burst lengths cover every legal value including full page, both orderings, all three CAS latencies, every refresh fraction and every drive fraction, and tRP values as short as one cycle. The bench checks every cycle against an arithmetic schedule. A design with an off-by-one in any wait counter would move a command by one cycle. A design that let one stage reuse another stage's wait would show up in the configurations where tRP, tRFC and tMRD all differ. A design that swapped the bank codes of the two loads, or that placed a field in the wrong bits, would corrupt the address word in configurations where that field is non-zero. A ready flag raised early or late would show on the exact cycle the bench expects it.

// File: rtl/sdram_boot_pkg.sv
`timescale 1ns/1ps
package sdram_boot_pkg;

   localparam int BANK_W = 2;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sdram_cmd_t;

   localparam sdram_cmd_t CMD_NOP  = sdram_cmd_t'(4'b0111);
   localparam sdram_cmd_t CMD_PALL = sdram_cmd_t'(4'b0010);
   localparam sdram_cmd_t CMD_AREF = sdram_cmd_t'(4'b0001);
   localparam sdram_cmd_t CMD_LDMR = sdram_cmd_t'(4'b0000);

   localparam logic [BANK_W-1:0] BANK_STD_REG = 2'b00;
   localparam logic [BANK_W-1:0] BANK_EXT_REG = 2'b10;

   typedef enum logic [2:0] {
      PH_POWERUP  = 3'd0,
      PH_PRECHG   = 3'd1,
      PH_REFR_A   = 3'd2,
      PH_REFR_B   = 3'd3,
      PH_LOAD_STD = 3'd4,
      PH_LOAD_EXT = 3'd5,
      PH_READY    = 3'd6
   } boot_phase_t;

   // log2 of an exact power of two, as a small code
   function automatic int pow2_code(input int value);
      int c;
      c = 0;
      for (int i = 1; i < 16; i++) begin
         if ((1 << i) <= value) c = i;
      end
      return c;
   endfunction

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
`timescale 1ns/1ps
module sdram_boot_timer #(
   parameter int CNT_W     = 8,
   parameter int RESET_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R4: once a wait has run out it stays out until a new value is loaded
   p_expired_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/sdram_boot_modeword.sv
`timescale 1ns/1ps
module sdram_boot_modeword #(
   parameter int ADDR_W       = 12,
   parameter int BURST_LEN    = 4,
   parameter bit INTERLEAVE   = 1'b0,
   parameter int CAS_LAT      = 2,
   parameter bit WRITE_SINGLE = 1'b0,
   parameter int PASR_FRAC    = 1,
   parameter int DRIVE_FRAC   = 1
) (
   output logic [ADDR_W-1:0] std_word,
   output logic [ADDR_W-1:0] ext_word
);
   import sdram_boot_pkg::*;

   localparam logic [2:0] CL_CODE    = 3'(CAS_LAT);
   localparam logic [2:0] PASR_CODE  = 3'(pow2_code(PASR_FRAC));
   localparam logic [1:0] DRIVE_CODE = 2'(pow2_code(DRIVE_FRAC));

   logic [2:0] burst_code;

   generate
      if (ADDR_W < 11) begin : g_bad_addr_w
         $error("sdram_boot_modeword: ADDR_W must be at least 11");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("sdram_boot_modeword: CAS_LAT must be 1, 2 or 3");
      end
      if (!(BURST_LEN inside {0, 1, 2, 4, 8})) begin : g_bad_bl
         $error("sdram_boot_modeword: BURST_LEN must be 0 (full page), 1, 2, 4 or 8");
      end
      if (BURST_LEN == 0 && INTERLEAVE) begin : g_bad_fp
         $error("sdram_boot_modeword: full page needs sequential ordering");
      end
      if (!(PASR_FRAC inside {1, 2, 4})) begin : g_bad_pasr
         $error("sdram_boot_modeword: PASR_FRAC must be 1, 2 or 4");
      end
      if (!(DRIVE_FRAC inside {1, 2, 4, 8})) begin : g_bad_drv
         $error("sdram_boot_modeword: DRIVE_FRAC must be 1, 2, 4 or 8");
      end

      if (BURST_LEN == 0) begin : g_full_page
         assign burst_code = 3'b111;
      end else begin : g_fixed_burst
         assign burst_code = 3'(pow2_code(BURST_LEN));
      end
   endgenerate

   always_comb begin
      std_word      = '0;
      std_word[2:0] = burst_code;
      std_word[3]   = INTERLEAVE;
      std_word[6:4] = CL_CODE;
      std_word[9]   = WRITE_SINGLE;
   end

   always_comb begin
      ext_word      = '0;
      ext_word[2:0] = PASR_CODE;
      ext_word[6:5] = DRIVE_CODE;
   end

endmodule

// File: rtl/sdram_boot_ctrl.sv
`timescale 1ns/1ps
module sdram_boot_ctrl #(
   parameter int ADDR_W    = 12,
   parameter int PWRUP_CYC = 10000,
   parameter int TRP_CYC   = 2,
   parameter int TRFC_CYC  = 8,
   parameter int TMRD_CYC  = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [ADDR_W-1:0]                  std_word,
   input  logic [ADDR_W-1:0]                  ext_word,
   output sdram_boot_pkg::sdram_cmd_t         nxt_cmd,
   output logic [sdram_boot_pkg::BANK_W-1:0]  nxt_ba,
   output logic [ADDR_W-1:0]                  nxt_addr,
   output logic                               nxt_done
);
   import sdram_boot_pkg::*;

   localparam int MAX_WAIT = max_of4(PWRUP_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   localparam logic [CNT_W-1:0] LD_TRP  = CNT_W'(TRP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TRFC = CNT_W'(TRFC_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TMRD = CNT_W'(TMRD_CYC - 1);

   generate
      if (PWRUP_CYC < 1) begin : g_bad_pwr
         $error("sdram_boot_ctrl: PWRUP_CYC must be at least 1");
      end
      if (TRP_CYC < 1) begin : g_bad_trp
         $error("sdram_boot_ctrl: TRP_CYC must be at least 1");
      end
      if (TRFC_CYC < 2) begin : g_bad_trfc
         $error("sdram_boot_ctrl: TRFC_CYC must be at least 2");
      end
      if (TMRD_CYC < 2) begin : g_bad_tmrd
         $error("sdram_boot_ctrl: TMRD_CYC must be at least 2");
      end
   endgenerate

   boot_phase_t      phase_q;
   logic             advance;
   logic [CNT_W-1:0] wait_val;
   logic             wait_over;

   sdram_boot_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (PWRUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (advance),
      .load_val (wait_val),
      .expired  (wait_over)
   );

   always_comb begin
      nxt_cmd  = CMD_NOP;
      nxt_ba   = '0;
      nxt_addr = '0;
      nxt_done = 1'b0;
      advance  = 1'b0;
      wait_val = '0;
      if (wait_over) begin
         unique case (phase_q)
            PH_POWERUP: begin
               advance = 1'b1;
            end
            PH_PRECHG: begin
               nxt_cmd      = CMD_PALL;
               nxt_addr[10] = 1'b1;
               advance      = 1'b1;
               wait_val     = LD_TRP;
            end
            PH_REFR_A, PH_REFR_B: begin
               nxt_cmd  = CMD_AREF;
               advance  = 1'b1;
               wait_val = LD_TRFC;
            end
            PH_LOAD_STD: begin
               nxt_cmd  = CMD_LDMR;
               nxt_ba   = BANK_STD_REG;
               nxt_addr = std_word;
               advance  = 1'b1;
               wait_val = LD_TMRD;
            end
            PH_LOAD_EXT: begin
               nxt_cmd  = CMD_LDMR;
               nxt_ba   = BANK_EXT_REG;
               nxt_addr = ext_word;
               advance  = 1'b1;
               wait_val = LD_TMRD;
            end
            default: begin
               nxt_done = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_POWERUP;
      end else if (advance) begin
         phase_q <= boot_phase_t'(phase_q + 3'd1);
      end
   end

   // R8: phases are visited strictly in order, one step at a time
   p_phase_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != $past(phase_q)) |-> (phase_q == boot_phase_t'($past(phase_q) + 3'd1)));

   // R7: the final phase is never left
   p_ready_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_READY) |=> (phase_q == PH_READY));

endmodule

// File: rtl/sdram_boot_seq.sv
`timescale 1ns/1ps
module sdram_boot_seq #(
   parameter int ADDR_W       = 12,
   parameter int PWRUP_CYC    = 10000,
   parameter int TRP_CYC      = 2,
   parameter int TRFC_CYC     = 8,
   parameter int TMRD_CYC     = 2,
   parameter int BURST_LEN    = 4,
   parameter bit INTERLEAVE   = 1'b0,
   parameter int CAS_LAT      = 2,
   parameter bit WRITE_SINGLE = 1'b0,
   parameter int PASR_FRAC    = 1,
   parameter int DRIVE_FRAC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);
   import sdram_boot_pkg::*;

   logic [ADDR_W-1:0] std_word;
   logic [ADDR_W-1:0] ext_word;
   sdram_cmd_t        nxt_cmd;
   logic [BANK_W-1:0] nxt_ba;
   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_done;

   sdram_cmd_t        cmd_q;
   logic [BANK_W-1:0] ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic              cke_q;

   sdram_boot_modeword #(
      .ADDR_W       (ADDR_W),
      .BURST_LEN    (BURST_LEN),
      .INTERLEAVE   (INTERLEAVE),
      .CAS_LAT      (CAS_LAT),
      .WRITE_SINGLE (WRITE_SINGLE),
      .PASR_FRAC    (PASR_FRAC),
      .DRIVE_FRAC   (DRIVE_FRAC)
   ) u_words (
      .std_word (std_word),
      .ext_word (ext_word)
   );

   sdram_boot_ctrl #(
      .ADDR_W    (ADDR_W),
      .PWRUP_CYC (PWRUP_CYC),
      .TRP_CYC   (TRP_CYC),
      .TRFC_CYC  (TRFC_CYC),
      .TMRD_CYC  (TMRD_CYC)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .std_word (std_word),
      .ext_word (ext_word),
      .nxt_cmd  (nxt_cmd),
      .nxt_ba   (nxt_ba),
      .nxt_addr (nxt_addr),
      .nxt_done (nxt_done)
   );

   // registered pad stage: every pin changes on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         done_q <= 1'b0;
         cke_q  <= 1'b1;
      end else begin
         cmd_q  <= nxt_cmd;
         ba_q   <= nxt_ba;
         addr_q <= nxt_addr;
         done_q <= nxt_done;
         cke_q  <= 1'b1;
      end
   end

   assign cke       = cke_q;
   assign cs_n      = cmd_q.cs_n;
   assign ras_n     = cmd_q.ras_n;
   assign cas_n     = cmd_q.cas_n;
   assign we_n      = cmd_q.we_n;
   assign ba        = ba_q;
   assign addr      = addr_q;
   assign init_done = done_q;

   // R3: precharge-all carries address bit 10
   p_pall_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_PALL) |-> addr_q[10]);

   // R4: a refresh is always followed by at least one idle cycle
   p_refresh_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_AREF) |=> (cmd_q == CMD_NOP));

   // R5: register loads only address the standard or extended register
   p_load_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LDMR) |-> (ba_q == BANK_STD_REG || ba_q == BANK_EXT_REG));

   // R6: a register load is followed by an idle cycle
   p_mrd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LDMR) |=> (cmd_q == CMD_NOP));

   // R7: ready is sticky and the bus is quiet once ready
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_boot_seq_test.sv
`timescale 1ns/1ps
module sdram_boot_seq_test;

   localparam int NCFG   = 8;
   localparam int ADDR_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   int   n_fin = 0;

   always #5 clk = ~clk;

   function automatic int cfg_bl(input int i);
      case (i)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         4: return 0;
         5: return 1;
         6: return 2;
         default: return 8;
      endcase
   endfunction
   function automatic int log2i(input int v);
      int r;
      r = 0;
      while ((1 << (r + 1)) <= v) r++;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int id,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cfg%0d: actual %0h expected %0h", req, id, act, exp);
      end
   endtask

   for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
      localparam int BL   = cfg_bl(gi);
      localparam bit IL   = (gi >= 5);
      localparam int CL   = gi % 3 + 1;
      localparam bit WS   = gi % 2;
      localparam int PF   = 1 << (gi % 3);
      localparam int DF   = 1 << (gi % 4);
      localparam int PWR  = 4 + gi * 3;
      localparam int TRP  = 1 + gi % 3;
      localparam int TRFC = 3 + gi;
      localparam int TMRD = 2 + gi % 2;

      logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
      logic [1:0]        ba;
      logic [ADDR_W-1:0] addr;

      sdram_boot_seq #(
         .ADDR_W (ADDR_W), .PWRUP_CYC (PWR), .TRP_CYC (TRP), .TRFC_CYC (TRFC),
         .TMRD_CYC (TMRD), .BURST_LEN (BL), .INTERLEAVE (IL), .CAS_LAT (CL),
         .WRITE_SINGLE (WS), .PASR_FRAC (PF), .DRIVE_FRAC (DF)
      ) uut (
         .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
         .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .init_done (init_done)
      );

      initial begin
         int k_pre, k_r1, k_r2, k_l1, k_l2, k_rdy;
         int blc, std_exp, ext_exp;
         logic [3:0] cmd;
         logic [3:0] cmd_exp;
         string tag;
         blc     = (BL == 0) ? 7 : log2i(BL);
         // R10 R11: standard word laid out from the natural parameters
         std_exp = (int'(WS) << 9) | (CL << 4) | (int'(IL) << 3) | blc;
         // R12: extended word
         ext_exp = (log2i(DF) << 5) | log2i(PF);
         k_pre = PWR + 1;
         k_r1  = k_pre + TRP;
         k_r2  = k_r1 + TRFC;
         k_l1  = k_r2 + TRFC;
         k_l2  = k_l1 + TMRD;
         k_rdy = k_l2 + TMRD;

         @(negedge clk);
         // R1: reset state
         chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", gi, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
         chk(init_done == 1'b0, "R1", gi, init_done, 0);
         chk(cke == 1'b1, "R9", gi, cke, 1);

         @(posedge rst_n);
         for (int k = 0; k <= k_rdy + 4; k++) begin
            if (k > 0) @(negedge clk);
            cmd = {cs_n, ras_n, cas_n, we_n};
            if (k == k_pre)                   begin cmd_exp = 4'b0010; tag = "R3"; end
            else if (k == k_r1 || k == k_r2)  begin cmd_exp = 4'b0001; tag = "R4"; end
            else if (k == k_l1)               begin cmd_exp = 4'b0000; tag = "R5"; end
            else if (k == k_l2)               begin cmd_exp = 4'b0000; tag = "R6"; end
            else if (k < k_pre)               begin cmd_exp = 4'b0111; tag = "R2"; end
            else if (k >= k_rdy)              begin cmd_exp = 4'b0111; tag = "R7"; end
            else                              begin cmd_exp = 4'b0111; tag = "R8"; end
            if (k == 0)
               chk(cmd == 4'b0111 && init_done == 1'b0, "R1", gi, {init_done, cmd}, 5'b00111);
            chk(cmd == cmd_exp, tag, gi, cmd, cmd_exp);
            chk(cke == 1'b1, "R9", gi, cke, 1);
            chk(init_done == (k >= k_rdy), "R7", gi, init_done, (k >= k_rdy));
            if (k == k_pre)
               chk(addr[10] == 1'b1, "R3", gi, addr, 12'h400);
            if (k == k_l1) begin
               chk(ba == 2'b00, "R5", gi, ba, 0);
               chk(addr[2:0] == std_exp[2:0] && addr[3] == std_exp[3], "R10", gi, addr, std_exp);
               chk(addr == ADDR_W'(std_exp), "R11", gi, addr, std_exp);
            end
            if (k == k_l2) begin
               chk(ba == 2'b10, "R6", gi, ba, 2);
               chk(addr == ADDR_W'(ext_exp), "R12", gi, addr, ext_exp);
            end
         end
         n_fin++;
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wait (n_fin == NCFG);
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule